// File: doc/BRIEF.md
# Extended-Precision Ordering Comparator

This block compares two 80-bit extended-precision floating-point operands. It does not form their difference. It returns an encoded 80-bit verdict word that stands for the relation between operand A and operand B. The verdict is one of three values:

- a signed 1.0 when the magnitudes differ, with the sign showing which side is larger;
- a signed zero when the operands are equal;
- the default quiet NaN when the operands are unordered.

The word is shaped so that ordinary condition-code logic (zero, negative, NaN) gives the compare flags directly. Infinity against infinity therefore gets a defined verdict. No subtraction takes place, so the result can carry no rounding and no overflow.

The operand layout is:

| Field | Bits |
|---|---|
| sign | 79 |
| exponent | 78:64 |
| significand, with an explicit integer bit at 63 | 63:0 |

The decision looks only at the signs, the exponent order and the significand order, in a fixed priority. Denormal operands are not normalised. No exception flags are produced.

An operand pair is presented with a strobe. The verdict appears in a register on the following clock edge, and a valid flag goes with it.

Top module: `xcmp_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_res` to zero.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low in the cycle after a cycle without the strobe. `out_res` holds the verdict for that strobed pair.
- R3: If either operand is a NaN (exponent all ones and significand bits 62:0 not all zero), the verdict is sign 0, exponent 0x7FFF, significand 0xC000000000000000.
- R4: Otherwise, if the exponent of A is greater than the exponent of B, the verdict is 1.0 (exponent 0x3FFF, significand 0x8000000000000000) with A's sign.
- R5: Otherwise, if the exponent of A is less than the exponent of B, the verdict is 1.0 with the inverse of B's sign.
- R6: Otherwise, if both exponents are 0x7FFF, the verdict is zero (exponent 0, significand 0) with A's sign when the signs agree, and 1.0 with A's sign when they differ. The significands are ignored in this case.
- R7: Otherwise, with equal exponents and unequal significands, the verdict is 1.0 with A's sign when A's significand is larger, and 1.0 with the inverse of B's sign when it is smaller.
- R8: Otherwise, with equal exponents and equal significands of value zero, the verdict is zero with A's sign.
- R9: Otherwise, with equal exponents and equal nonzero significands, the verdict is +0 when the signs agree and 1.0 with A's sign when they differ.
- R10: In a cycle after one without the strobe, `out_res` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| a_op | input | 80 | Operand A (sign, exponent, significand) |
| b_op | input | 80 | Operand B (sign, exponent, significand) |
| out_valid | output | 1 | Verdict valid, one cycle after the strobe |
| out_res | output | 80 | Registered verdict word |

## Verification
A wrong priority or a wrong magnitude order shows at the ports one cycle after the strobe, as a verdict word with the wrong sign or the wrong kind. Typical cases are a 1.0 where a zero belongs, or a finite verdict where the NaN word belongs. The bench sweeps every ordered pair from a set of operands picked to sit on each rule boundary. The set includes:

- signed zeros and infinities;
- a pseudo-infinity with a clear integer bit;
- quiet and signalling NaNs;
- an unnormal with a zero significand;
- a denormal;
- values one ulp apart.

A stale result register or a misaligned valid flag is visible in the idle cycles placed between strobes.

// File: rtl/xcmp_pkg.sv
package xcmp_pkg;

    localparam int XC_EXP_W = 15;
    localparam int XC_SIG_W = 64;

    typedef enum logic [1:0] {
        VK_ZERO = 2'd0,
        VK_ONE  = 2'd1,
        VK_NAN  = 2'd2
    } verdict_kind_e;

    typedef struct packed {
        verdict_kind_e kind;
        logic          sign;
    } verdict_t;

    typedef struct packed {
        logic is_nan;
        logic is_top;
    } opnd_class_t;

endpackage

// File: rtl/xcmp_classify.sv
module xcmp_classify #(
    parameter int EXP_W = xcmp_pkg::XC_EXP_W,
    parameter int SIG_W = xcmp_pkg::XC_SIG_W
) (
    input  logic [EXP_W-1:0]       exp_i,
    input  logic [SIG_W-1:0]       sig_i,
    output xcmp_pkg::opnd_class_t  cls_o
);
    // Fraction bits below the explicit integer bit.
    localparam int FRAC_W = SIG_W - 1;

    always_comb begin
        cls_o.is_top = &exp_i;
        cls_o.is_nan = (&exp_i) && (|sig_i[FRAC_W-1:0]);
    end
endmodule

// File: rtl/xcmp_order.sv
module xcmp_order #(
    parameter int EXP_W = xcmp_pkg::XC_EXP_W,
    parameter int SIG_W = xcmp_pkg::XC_SIG_W
) (
    input  logic                  a_sign,
    input  logic [EXP_W-1:0]      a_exp,
    input  logic [SIG_W-1:0]      a_sig,
    input  xcmp_pkg::opnd_class_t a_cls,
    input  logic                  b_sign,
    input  logic [EXP_W-1:0]      b_exp,
    input  logic [SIG_W-1:0]      b_sig,
    input  xcmp_pkg::opnd_class_t b_cls,
    output xcmp_pkg::verdict_t    verdict_o
);
    import xcmp_pkg::*;

    logic exp_gt, exp_lt, sig_gt, sig_lt, sig_zero, signs_eq;

    always_comb begin
        exp_gt   = a_exp > b_exp;
        exp_lt   = a_exp < b_exp;
        sig_gt   = a_sig > b_sig;
        sig_lt   = a_sig < b_sig;
        sig_zero = (a_sig == '0);
        signs_eq = (a_sign == b_sign);
    end

    // Fixed priority: NaN, exponent order, infinities, significand order, equality.
    always_comb begin
        verdict_o.kind = VK_ONE;
        verdict_o.sign = a_sign;
        if (a_cls.is_nan || b_cls.is_nan) begin
            verdict_o.kind = VK_NAN;
            verdict_o.sign = 1'b0;
        end else if (exp_gt) begin
            verdict_o.kind = VK_ONE;
        end else if (exp_lt) begin
            verdict_o.sign = ~b_sign;
        end else if (a_cls.is_top) begin
            verdict_o.kind = signs_eq ? VK_ZERO : VK_ONE;
        end else if (sig_gt) begin
            verdict_o.kind = VK_ONE;
        end else if (sig_lt) begin
            verdict_o.sign = ~b_sign;
        end else if (sig_zero) begin
            verdict_o.kind = VK_ZERO;
        end else if (signs_eq) begin
            verdict_o.kind = VK_ZERO;
            verdict_o.sign = 1'b0;
        end
    end
endmodule

// File: rtl/xcmp_pack.sv
module xcmp_pack #(
    parameter int EXP_W = xcmp_pkg::XC_EXP_W,
    parameter int SIG_W = xcmp_pkg::XC_SIG_W
) (
    input  xcmp_pkg::verdict_t     verdict_i,
    output logic [EXP_W+SIG_W:0]   word_o
);
    import xcmp_pkg::*;

    localparam logic [EXP_W-1:0] BIAS_EXP = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] TOP_EXP  = {EXP_W{1'b1}};
    localparam logic [SIG_W-1:0] ONE_SIG  = {1'b1, {(SIG_W-1){1'b0}}};
    localparam logic [SIG_W-1:0] QNAN_SIG = {2'b11, {(SIG_W-2){1'b0}}};

    always_comb begin
        unique case (verdict_i.kind)
            VK_ONE:  word_o = {verdict_i.sign, BIAS_EXP, ONE_SIG};
            VK_NAN:  word_o = {1'b0, TOP_EXP, QNAN_SIG};
            default: word_o = {verdict_i.sign, {EXP_W{1'b0}}, {SIG_W{1'b0}}};
        endcase
    end
endmodule

// File: rtl/xcmp_unit.sv
module xcmp_unit #(
    parameter int EXP_W = xcmp_pkg::XC_EXP_W,
    parameter int SIG_W = xcmp_pkg::XC_SIG_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [EXP_W+SIG_W:0]   a_op,
    input  logic [EXP_W+SIG_W:0]   b_op,
    output logic                   out_valid,
    output logic [EXP_W+SIG_W:0]   out_res
);
    import xcmp_pkg::*;

    localparam int OP_W   = EXP_W + SIG_W + 1;
    localparam int SIGN_B = OP_W - 1;

    logic [1:0]             op_sign;
    logic [1:0][EXP_W-1:0]  op_exp;
    logic [1:0][SIG_W-1:0]  op_sig;
    opnd_class_t            op_cls [2];
    verdict_t               verdict;
    logic [OP_W-1:0]        verdict_word;

    always_comb begin
        op_sign[0] = a_op[SIGN_B];
        op_exp[0]  = a_op[SIGN_B-1 -: EXP_W];
        op_sig[0]  = a_op[SIG_W-1:0];
        op_sign[1] = b_op[SIGN_B];
        op_exp[1]  = b_op[SIGN_B-1 -: EXP_W];
        op_sig[1]  = b_op[SIG_W-1:0];
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        xcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .exp_i (op_exp[gi]),
            .sig_i (op_sig[gi]),
            .cls_o (op_cls[gi])
        );
    end

    xcmp_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
        .a_sign    (op_sign[0]),
        .a_exp     (op_exp[0]),
        .a_sig     (op_sig[0]),
        .a_cls     (op_cls[0]),
        .b_sign    (op_sign[1]),
        .b_exp     (op_exp[1]),
        .b_sig     (op_sig[1]),
        .b_cls     (op_cls[1]),
        .verdict_o (verdict)
    );

    xcmp_pack #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_pack (
        .verdict_i (verdict),
        .word_o    (verdict_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_res <= verdict_word;
        end
    end
endmodule

// File: rtl/xcmp_unit_chk.sv
module xcmp_unit_chk #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [EXP_W+SIG_W:0] a_op,
    input logic [EXP_W+SIG_W:0] b_op,
    input logic                 out_valid,
    input logic [EXP_W+SIG_W:0] out_res
);
    localparam int OP_W = EXP_W + SIG_W + 1;
    localparam logic [EXP_W-1:0] TOPE  = {EXP_W{1'b1}};
    localparam logic [OP_W-1:0]  QNAN  = {1'b0, TOPE, 2'b11, {(SIG_W-2){1'b0}}};
    localparam logic [EXP_W+SIG_W-1:0] ONE_MAG =
        {1'b0, {(EXP_W-1){1'b1}}, 1'b1, {(SIG_W-1){1'b0}}};

    logic [EXP_W-1:0] ae, be;
    logic a_nan, b_nan, unordered;

    assign ae        = a_op[OP_W-2 -: EXP_W];
    assign be        = b_op[OP_W-2 -: EXP_W];
    assign a_nan     = (ae == TOPE) && (a_op[SIG_W-2:0] != '0);
    assign b_nan     = (be == TOPE) && (b_op[SIG_W-2:0] != '0);
    assign unordered = a_nan || b_nan;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_nan_word_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && unordered |=> out_res == QNAN);
    assert_exp_greater_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && !unordered && ae > be |=> out_res == {$past(a_op[OP_W-1]), ONE_MAG});
    assert_exp_smaller_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && !unordered && ae < be |=> out_res == {~$past(b_op[OP_W-1]), ONE_MAG});
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_res));
endmodule

bind xcmp_unit xcmp_unit_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_op      (a_op),
    .b_op      (b_op),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/xcmp_unit_tb.sv
module xcmp_unit_tb;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [79:0] a_op = '0;
    logic [79:0] b_op = '0;
    logic        out_valid;
    logic [79:0] out_res;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    xcmp_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_op      (a_op),
        .b_op      (b_op),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
        return {s, e, m};
    endfunction

    function automatic logic [79:0] pick(input int i);
        case (i)
            0:  return mk(0, 15'h0000, 64'h0);
            1:  return mk(1, 15'h0000, 64'h0);
            2:  return mk(0, 15'h3FFF, 64'h8000_0000_0000_0000);
            3:  return mk(1, 15'h3FFF, 64'h8000_0000_0000_0000);
            4:  return mk(0, 15'h3FFF, 64'hC000_0000_0000_0000);
            5:  return mk(1, 15'h4000, 64'h8000_0000_0000_0000);
            6:  return mk(0, 15'h7FFF, 64'h8000_0000_0000_0000);
            7:  return mk(1, 15'h7FFF, 64'h8000_0000_0000_0000);
            8:  return mk(0, 15'h7FFF, 64'h0);
            9:  return mk(0, 15'h7FFF, 64'hC000_0000_0000_0000);
            10: return mk(1, 15'h7FFF, 64'h8000_0000_0000_0001);
            11: return mk(0, 15'h0005, 64'h0);
            12: return mk(0, 15'h3FFF, 64'h8000_0000_0000_0001);
            default: return mk(1, 15'h0000, 64'h1);
        endcase
    endfunction

    // Reference verdict built from the requirements.
    function automatic void model(input logic [79:0] a, input logic [79:0] b,
                                  output logic [79:0] r, output string tag);
        logic [78:0] ma, mb;
        logic sa, sb, na, nb;
        logic [79:0] one_a, one_nb, zero_a;
        sa = a[79]; sb = b[79];
        ma = a[78:0]; mb = b[78:0];
        na = (a[78:64] == 15'h7FFF) && (a[62:0] != 0);
        nb = (b[78:64] == 15'h7FFF) && (b[62:0] != 0);
        one_a  = mk(sa, 15'h3FFF, 64'h8000_0000_0000_0000);
        one_nb = mk(~sb, 15'h3FFF, 64'h8000_0000_0000_0000);
        zero_a = mk(sa, 15'h0, 64'h0);
        if (na || nb) begin
            r = mk(0, 15'h7FFF, 64'hC000_0000_0000_0000); tag = "R3";
        end else if (a[78:64] > b[78:64]) begin
            r = one_a; tag = "R4";
        end else if (a[78:64] < b[78:64]) begin
            r = one_nb; tag = "R5";
        end else if (a[78:64] == 15'h7FFF) begin
            r = (sa == sb) ? zero_a : one_a; tag = "R6";
        end else if (ma != mb) begin
            r = (ma > mb) ? one_a : one_nb; tag = "R7";
        end else if (a[63:0] == 0) begin
            r = zero_a; tag = "R8";
        end else begin
            r = (sa == sb) ? mk(0, 15'h0, 64'h0) : one_a; tag = "R9";
        end
    endfunction

    task automatic check(input logic [79:0] got, input logic [79:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [79:0] exp_r;
        logic [79:0] last_r;
        string tag;
        last_r = '0;
        repeat (3) @(negedge clk);
        // R1: after reset
        check({79'b0, out_valid}, 80'h0, "R1");
        check(out_res, 80'h0, "R1");
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < NV; j++) begin
                a_op = pick(i);
                b_op = pick(j);
                in_valid = 1'b1;
                model(a_op, b_op, exp_r, tag);
                @(negedge clk);
                // R2: valid one cycle after the strobe
                check({79'b0, out_valid}, 80'h1, "R2");
                check(out_res, exp_r, tag);
                last_r = exp_r;
                if (((i * NV + j) % 5) == 0) begin
                    // R10: idle cycle with different operands applied
                    in_valid = 1'b0;
                    a_op = pick((i + 3) % NV);
                    b_op = pick((j + 7) % NV);
                    @(negedge clk);
                    check({79'b0, out_valid}, 80'h0, "R2");
                    check(out_res, last_r, "R10");
                end
            end
        end
        // R1: reset in mid-run clears the result
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check({79'b0, out_valid}, 80'h0, "R1");
        check(out_res, 80'h0, "R1");
        rst = 1'b0;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule